// File: doc/BRIEF.md
# Random Number Generator Register Peripheral

This block puts a pseudo-random word source behind a small 32-bit register bus. The bus has a select strobe, a write flag, an address and write data, and it returns read data combinationally. Software loads a warm-up count, sets the enable bit and then reads random words one at a time from a data register. Each read removes one word from an internal FIFO. The status register shows how many words are waiting, and an interrupt line rises once that number reaches a programmable threshold, unless the interrupt is masked.

The generator advances on a tick enable. That tick comes from one of three sources: an internal jitter stand-in that ticks every `INT_JIT_DIV` bus cycles, the undivided bus clock, or a divided bus clock. A 32-bit LFSR stands in for the oscillator entropy. One word is pushed into the FIFO after a fixed number of ticks, and the interval is halved in double-speed mode. No word is produced until the warm-up counter has counted down to zero.

Top module: `rng_periph`

## Requirements
- R1: After reset, the register reads are: control 0, status 0 (FIFO count 0, warm-up 0), threshold 16 and mask 0. The `irq` output is low.
- R2: The control register at address 0x00 stores and reads back these fields:
  - bit 0 enable;
  - bit 1 double speed;
  - bit 4 jitter bypass;
  - bit 5 bypass source (1 = divided clock);
  - bits 15:8 divider N;
  - bits 21:16 and 27:22 the two 6-bit oscillator masks.

  All other bits read 0.
- R3: Writing status (address 0x04) loads bits 19:0 into the warm-up counter, and reading status returns that counter in bits 19:0. While the block is enabled, the counter decrements by one on each tick until it reaches 0. No word is pushed while it is nonzero.
- R4: With bypass on and source 0, the block ticks on every bus cycle. After warm-up, one word is pushed every 8 ticks. After a control write that enables the block with warm-up W, the count first reads 1 exactly W+8 clock edges after the write edge.
- R5: With bit 1 set, one word is pushed every 4 ticks.
- R6: With bypass on and source 1, the block ticks once every 2*(N+1) bus cycles. With N=2 and warm-up 0, the first word appears 48 edges after the enabling write.
- R7: With bypass off, the block ticks once every 3 bus cycles (the internal stand-in). With warm-up 0, the first word appears 24 edges after the enabling write.
- R8: A read of the data register (address 0x08) returns the oldest word, which is nonzero, and decrements the count in status bits 31:24. Successive words differ.
- R9: A data read while the FIFO is empty returns 0, and the count stays 0.
- R10: The count saturates at the FIFO depth of 16. Words produced while the FIFO is full are dropped.
- R11: Clearing the enable bit stops generation. The count and the stored words are kept and remain readable.
- R12: `irq` is high exactly when the count is at least the threshold (address 0x0C, 5 bits, so writing 0x3F reads back 0x1F) and mask bit 0 (address 0x10) is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while a read is selected |
| irq | output | 1 | FIFO-level interrupt |

## Verification
The bench measures the exact edge on which the first word appears for each tick source and for both speeds. A design that miscounts the warm-up, uses the wrong divider formula or drops the halving in double-speed mode shows a count that moves one or more edges early or late. The bench fills the FIFO past its depth and drains it word by word, which exposes a count that wraps or a pop that misses. It reads the empty FIFO to catch stale data or an underflowing count. It also holds the block disabled with a word stored to catch lost contents, and toggles the mask and the threshold to catch an interrupt that ignores either.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int unsigned BUS_W = 32;

  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_DATA = 8'h08;
  localparam logic [7:0] OFS_THR  = 8'h0C;
  localparam logic [7:0] OFS_MASK = 8'h10;

  localparam logic [4:0] THR_RESET = 5'd16;

  typedef struct packed {
    logic [5:0] osc_b;
    logic [5:0] osc_a;
    logic [7:0] div_n;
    logic       byp_src;
    logic       byp_sel;
    logic       dbl;
    logic       en;
  } ctrl_t;
endpackage

// File: rtl/rng_tick_gen.sv
module rng_tick_gen #(
  parameter int unsigned DIV_W       = 8,
  parameter int unsigned INT_JIT_DIV = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             byp_sel,
  input  logic             byp_src,
  input  logic [DIV_W-1:0] div_n,
  output logic             tick
);
  localparam int unsigned LIM_W = DIV_W + 2;

  logic [LIM_W-1:0] cnt_q, cnt_d, limit;
  logic             wrap;

  always_comb begin
    if (byp_sel) begin
      if (byp_src) limit = {1'b0, div_n, 1'b0} + LIM_W'(2);
      else         limit = LIM_W'(1);
    end else begin
      limit = LIM_W'(INT_JIT_DIV);
    end
    wrap = (cnt_q >= (limit - LIM_W'(1)));
    tick = run && wrap;
    if (!run)      cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt_q + LIM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rng_word_src.sv
module rng_word_src #(
  parameter int unsigned WARM_W     = 20,
  parameter int unsigned WORD_TICKS = 8,
  parameter logic [31:0] SEED       = 32'h1D87_2B41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              tick,
  input  logic              dbl,
  input  logic              warm_ld,
  input  logic [WARM_W-1:0] warm_val,
  output logic [WARM_W-1:0] warm_q,
  output logic [31:0]       word,
  output logic              word_vld
);
  localparam int unsigned PER_W = $clog2(WORD_TICKS + 1);
  localparam logic [31:0] POLY  = 32'h8020_0003;

  logic [31:0]       lfsr_q, lfsr_d;
  logic [WARM_W-1:0] warm_d;
  logic [PER_W-1:0]  phase_q, phase_d, period;
  logic              warm_done, last_tick;

  always_comb begin
    period    = dbl ? PER_W'(WORD_TICKS / 2) : PER_W'(WORD_TICKS);
    warm_done = (warm_q == '0);
    last_tick = (phase_q >= (period - PER_W'(1)));
    word_vld  = tick && warm_done && last_tick && !warm_ld;
    word      = lfsr_q;

    lfsr_d = lfsr_q;
    if (tick) lfsr_d = {1'b0, lfsr_q[31:1]} ^ (lfsr_q[0] ? POLY : 32'h0);

    warm_d = warm_q;
    if (warm_ld)                 warm_d = warm_val;
    else if (tick && !warm_done) warm_d = warm_q - WARM_W'(1);

    phase_d = phase_q;
    if (!run || warm_ld)        phase_d = '0;
    else if (tick && warm_done) phase_d = last_tick ? '0 : phase_q + PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lfsr_q  <= SEED;
      warm_q  <= '0;
      phase_q <= '0;
    end else begin
      lfsr_q  <= lfsr_d;
      warm_q  <= warm_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/rng_fifo.sv
module rng_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 32,
  parameter int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] cnt
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty, full, do_push, do_pop;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == CNT_W'(DEPTH));
    do_pop  = pop && !empty;
    do_push = push && (!full || do_pop);

    wr_d = wr_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    rd_d = rd_q;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);

    cnt_d = cnt_q;
    if (do_push && !do_pop)      cnt_d = cnt_q + CNT_W'(1);
    else if (do_pop && !do_push) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= din;
  end

  assign dout = mem[rd_q];
  assign cnt  = cnt_q;
endmodule

// File: rtl/rng_periph.sv
module rng_periph
  import rng_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned WARM_W      = 20,
  parameter int unsigned WORD_TICKS  = 8,
  parameter int unsigned INT_JIT_DIV = 3,
  parameter logic [31:0] SEED        = 32'h1D87_2B41
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam int unsigned PAD_W = BUS_W - 8 - WARM_W;

  logic [1:0]        rst_sync_q;
  logic              rst_s;
  ctrl_t             ctrl_q, ctrl_d;
  logic [4:0]        thr_q, thr_d;
  logic              mask_q, mask_d;
  logic              wr_ctrl, wr_stat, wr_thr, wr_mask, rd_acc, rd_pop;
  logic              tick, push;
  logic [WARM_W-1:0] warm_q;
  logic [31:0]       word, head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              unused_wbits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  always_comb begin
    wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL[ADDR_W-1:0]);
    wr_stat = bus_sel && bus_wr && (bus_addr == OFS_STAT[ADDR_W-1:0]);
    wr_thr  = bus_sel && bus_wr && (bus_addr == OFS_THR[ADDR_W-1:0]);
    wr_mask = bus_sel && bus_wr && (bus_addr == OFS_MASK[ADDR_W-1:0]);
    rd_acc  = bus_sel && !bus_wr;
    rd_pop  = rd_acc && (bus_addr == OFS_DATA[ADDR_W-1:0]);
  end

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d.en      = bus_wdata[0];
      ctrl_d.dbl     = bus_wdata[1];
      ctrl_d.byp_sel = bus_wdata[4];
      ctrl_d.byp_src = bus_wdata[5];
      ctrl_d.div_n   = bus_wdata[15:8];
      ctrl_d.osc_a   = bus_wdata[21:16];
      ctrl_d.osc_b   = bus_wdata[27:22];
    end
    thr_d  = wr_thr  ? bus_wdata[4:0] : thr_q;
    mask_d = wr_mask ? bus_wdata[0]   : mask_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctrl_q <= '0;
      thr_q  <= THR_RESET;
      mask_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      thr_q  <= thr_d;
      mask_q <= mask_d;
    end
  end

  assign unused_wbits = ^{bus_wdata[31:28], bus_wdata[7:6], bus_wdata[3:2]};

  rng_tick_gen #(
    .DIV_W       (8),
    .INT_JIT_DIV (INT_JIT_DIV)
  ) u_tick (
    .clk     (clk),
    .rst_n   (rst_s),
    .run     (ctrl_q.en),
    .byp_sel (ctrl_q.byp_sel),
    .byp_src (ctrl_q.byp_src),
    .div_n   (ctrl_q.div_n),
    .tick    (tick)
  );

  rng_word_src #(
    .WARM_W     (WARM_W),
    .WORD_TICKS (WORD_TICKS),
    .SEED       (SEED)
  ) u_src (
    .clk      (clk),
    .rst_n    (rst_s),
    .run      (ctrl_q.en),
    .tick     (tick),
    .dbl      (ctrl_q.dbl),
    .warm_ld  (wr_stat),
    .warm_val (bus_wdata[WARM_W-1:0]),
    .warm_q   (warm_q),
    .word     (word),
    .word_vld (push)
  );

  rng_fifo #(
    .DEPTH (DEPTH),
    .W     (32)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_s),
    .push  (push),
    .din   (word),
    .pop   (rd_pop),
    .dout  (head),
    .cnt   (fifo_cnt)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      case (bus_addr)
        OFS_CTRL[ADDR_W-1:0]:
          bus_rdata = {4'b0, ctrl_q.osc_b, ctrl_q.osc_a, ctrl_q.div_n, 2'b0,
                       ctrl_q.byp_src, ctrl_q.byp_sel, 2'b0, ctrl_q.dbl, ctrl_q.en};
        OFS_STAT[ADDR_W-1:0]:
          bus_rdata = {8'(fifo_cnt), {PAD_W{1'b0}}, warm_q};
        OFS_DATA[ADDR_W-1:0]:
          bus_rdata = (fifo_cnt == '0) ? 32'h0 : head;
        OFS_THR[ADDR_W-1:0]:
          bus_rdata = {27'b0, thr_q};
        OFS_MASK[ADDR_W-1:0]:
          bus_rdata = {31'b0, mask_q};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq = !mask_q && (32'(fifo_cnt) >= 32'(thr_q));
endmodule

// File: rtl/rng_periph_chk.sv
module rng_periph_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned CNT_W  = 5,
  parameter int unsigned WARM_W = 20
) (
  input logic              clk,
  input logic              rst_s,
  input logic              rd_pop,
  input logic              en,
  input logic              mask,
  input logic              push,
  input logic              irq,
  input logic [31:0]       bus_rdata,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic [WARM_W-1:0] warm_q
);
  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_s)
    32'(fifo_cnt) <= DEPTH);

  // R11
  frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !en |=> fifo_cnt <= $past(fifo_cnt));

  // R3
  no_word_in_warmup_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (warm_q != '0) |=> fifo_cnt <= $past(fifo_cnt));

  // R8
  pop_drops_count_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_pop && fifo_cnt != '0 && !push) |=> fifo_cnt == $past(fifo_cnt) - CNT_W'(1));

  // R9
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (rd_pop && fifo_cnt == '0) |-> bus_rdata == 32'h0);

  // R12
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_s)
    irq |-> !mask);
endmodule

bind rng_periph rng_periph_chk #(
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W),
  .WARM_W (WARM_W)
) u_chk (
  .clk       (clk),
  .rst_s     (rst_s),
  .rd_pop    (rd_pop),
  .en        (ctrl_q.en),
  .mask      (mask_q),
  .push      (push),
  .irq       (irq),
  .bus_rdata (bus_rdata),
  .fifo_cnt  (fifo_cnt),
  .warm_q    (warm_q)
);

// File: tb/sim_rng_periph.sv
`timescale 1ns/1ps
module sim_rng_periph;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] prev_word = '0;

  always #2.5 clk = ~clk;

  rng_periph u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_true(input string tag, input bit cond, input logic [31:0] act);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s: actual %h expected condition true", tag, act);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    @(posedge clk);
    #1;
    bus_sel = 1'b0;
  endtask

  task automatic peek(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] cnt_of(input logic [31:0] s);
    return {24'b0, s[31:24]};
  endfunction

  // first word must appear exactly n edges after the enabling write
  task automatic first_word_at(input string tag, input int n);
    logic [31:0] s;
    edges(n - 1);
    peek(5'h04, s);
    check({tag, " count before"}, cnt_of(s), 32'd0);
    edges(1);
    peek(5'h04, s);
    check({tag, " count at edge"}, cnt_of(s), 32'd1);
  endtask

  task automatic drain_one(input string tag, input logic [31:0] off_ctrl);
    logic [31:0] w, s;
    bus_write(5'h00, off_ctrl);
    bus_read(5'h08, w);
    check_true({tag, " R8 word nonzero"}, w != 32'h0, w);
    check_true({tag, " R8 word differs"}, w != prev_word, w);
    prev_word = w;
    peek(5'h04, s);
    check({tag, " R8 count after pop"}, cnt_of(s), 32'd0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    peek(5'h00, d); check("R1 ctrl", d, 32'h0);
    peek(5'h04, d); check("R1 status", d, 32'h0);
    peek(5'h0C, d); check("R1 threshold", d, 32'd16);
    peek(5'h10, d); check("R1 mask", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ctrl_fields;
    logic [31:0] d;
    bus_write(5'h00, 32'hFFFF_FFFE);
    peek(5'h00, d); check("R2 ctrl fields", d, 32'h0FFF_FF32);
    bus_write(5'h00, 32'h0A5C_3A21);
    peek(5'h00, d); check("R2 ctrl pattern", d, 32'h0A5C_3A20 | 32'h1);
    bus_write(5'h00, 32'h0);
    peek(5'h00, d); check("R2 ctrl cleared", d, 32'h0);
  endtask

  task automatic t_warm_normal;
    logic [31:0] s, w;
    bus_write(5'h04, 32'd5);
    peek(5'h04, s); check("R3 warm readback", s, 32'd5);
    bus_write(5'h00, 32'h11);
    edges(2);
    peek(5'h04, s); check("R3 warm decrement", s, 32'd3);
    first_word_at("R4 warm5 normal", 11);
    peek(5'h04, s); check("R3 warm done", s & 32'hFFFFF, 32'd0);
    bus_write(5'h00, 32'h10);
    edges(50);
    peek(5'h04, s); check("R11 count held while off", cnt_of(s), 32'd1);
    bus_read(5'h08, w);
    check_true("R11 word kept nonzero", w != 32'h0, w);
    prev_word = w;
    peek(5'h04, s); check("R8 count after pop", cnt_of(s), 32'd0);
    bus_read(5'h08, w); check("R9 empty read data", w, 32'h0);
    peek(5'h04, s); check("R9 empty count", cnt_of(s), 32'd0);
  endtask

  task automatic t_double;
    bus_write(5'h00, 32'h13);
    first_word_at("R5 double speed", 4);
    drain_one("R5", 32'h12);
  endtask

  task automatic t_divided;
    bus_write(5'h00, 32'h0231);
    first_word_at("R6 divided N2", 48);
    drain_one("R6", 32'h0230);
  endtask

  task automatic t_internal;
    bus_write(5'h00, 32'h01);
    first_word_at("R7 internal", 24);
    drain_one("R7", 32'h00);
  endtask

  task automatic t_full_irq;
    logic [31:0] s, w;
    bus_write(5'h0C, 32'd4);
    bus_write(5'h00, 32'h13);
    edges(15);
    check("R12 irq below threshold", {31'b0, irq}, 32'h0);
    edges(1);
    check("R12 irq at threshold", {31'b0, irq}, 32'h1);
    bus_write(5'h10, 32'h1);
    check("R12 irq masked", {31'b0, irq}, 32'h0);
    edges(200);
    peek(5'h04, s); check("R10 count saturates", cnt_of(s), 32'd16);
    bus_write(5'h00, 32'h12);
    for (int i = 0; i < 16; i++) begin
      bus_read(5'h08, w);
      check_true("R8 drained word nonzero", w != 32'h0, w);
      check_true("R8 drained word differs", w != prev_word, w);
      prev_word = w;
      peek(5'h04, s);
      check("R10 count while draining", cnt_of(s), 32'(15 - i));
    end
    bus_read(5'h08, w); check("R9 read after drain", w, 32'h0);
    bus_write(5'h10, 32'h0);
    check("R12 irq empty unmasked", {31'b0, irq}, 32'h0);
    bus_write(5'h0C, 32'h0);
    check("R12 irq threshold zero", {31'b0, irq}, 32'h1);
    bus_write(5'h0C, 32'h3F);
    peek(5'h0C, s); check("R12 threshold width", s, 32'h1F);
    peek(5'h10, s); check("R12 mask readback", s, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    edges(4);
    t_reset();
    t_ctrl_fields();
    t_warm_normal();
    t_double();
    t_divided();
    t_internal();
    t_full_irq();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule